// File: doc/BRIEF.md
# 8-bit ALU with Condition Flags

This unit is the arithmetic and logic core of a small accumulator machine. It combines two 8-bit operands under a 5-bit operation code and produces an 8-bit result, with a strobe that says whether the result should be written back. It also holds the machine's 8-bit condition register. The register keeps the overflow, half-carry, negative, zero and carry flags, a reserved bit, and a two-bit interrupt mask split across two bit positions.

The result path is purely combinational. The condition register changes only on a rising clock edge. Arithmetic flags change when `op_valid` is high. The mask bits are loaded from software through `mask_load`, and they are forced to all-ones when `irq_enter` pulses. The stored carry acts as the carry-in for add-with-carry, the borrow-in for subtract-with-borrow, the link bit for rotates, and the destination of a single-bit test.

Top module: `alu8_flags`

## Requirements
- R1: While `rst` is high at a rising edge, the condition register becomes 0x28 after that edge: both mask bits are 1 and every other bit is 0.
- R2: The condition register bit positions are: V=bit 7, reserved=bit 6, I1=bit 5, H=bit 4, I0=bit 3, N=bit 2, Z=bit 1, C=bit 0. The reserved bit always reads 0.
- R3: Code 0 (add) gives A+B. Code 1 (add with carry) gives A+B+C. Both set C to the carry out of bit 7 and H to the carry out of bit 3. V is set to the carry into bit 7 XOR the carry out of bit 7.
- R4: Code 2 (subtract) gives A-B, and code 3 gives A-B-C. Both set C to the borrow and V to signed overflow, and leave H unchanged. Code 4 (compare) updates flags as code 2 does but drops `res_we`.
- R5: Code 5 gives A+1, with V set when A=0x7F. Code 6 gives A-1, with V set when A=0x80. Both leave C and H unchanged. Code 7 gives 0-A, with V set when A=0x80 and C set when A is nonzero.
- R6: N takes result bit 7 and Z is set when the result is 0 for codes 0-12 and 14-18. The logic codes 8 (AND), 9 (OR), 10 (XOR), 11 (complement of A) and code 12 (move B) change only N and Z.
- R7: Code 14 rotates left through C, code 15 rotates right through C, code 16 shifts left, code 17 shifts right logically and code 18 shifts right arithmetically. Each loads C with the bit shifted out and leaves V and H unchanged.
- R8: Code 13 copies bit `bit_sel` of A into C, changes no other flag and drops `res_we`.
- R9: Code 19 sets C to 1 and code 20 clears C to 0. Neither changes any other bit.
- R10: `irq_enter` high at an edge sets I1 and I0 to 1, whatever `op_valid` or `mask_load` hold.
- R11: `mask_load` without `irq_enter` loads I1 from `mask_wdata[1]` and I0 from `mask_wdata[0]`. When neither is high, the mask bits hold.
- R12: With `op_valid` low, or for codes 21-31, V, H, N, Z and C hold their values.
- R13: `res_we` is high only when `op_valid` is high and the code is 0-3, 5-12 or 14-18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe; allows flag update and write-back |
| op_sel | input | 5 | Operation code |
| opa | input | 8 | Operand A (accumulator side) |
| opb | input | 8 | Operand B |
| bit_sel | input | 3 | Bit index for the bit test |
| irq_enter | input | 1 | Interrupt entry: forces both mask bits to 1 |
| mask_load | input | 1 | Software load of the mask bits |
| mask_wdata | input | 2 | New mask value {I1, I0} |
| result | output | 8 | Operation result (combinational) |
| res_we | output | 1 | Result should be written back |
| ccr | output | 8 | Condition register {V,0,I1,H,I0,N,Z,C} |

## Verification
The bound checker watches the properties that hold on every cycle:
- the reset value;
- N and Z tracking the previous result;
- flags holding when no operation is strobed;
- the bit test, set-carry and clear-carry touching only C;
- interrupt entry winning over a mask load;
- compare never requesting a write.

The arithmetic itself needs the bench's reference model, which recomputes each operation with signed and unsigned integer arithmetic. That covers:
- the exact result values, carry, borrow, half-carry and overflow across boundary operands such as 0x7F, 0x80, 0x00 and 0xFF;
- carry-in and link behaviour after a previous operation has set or cleared C.

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic       clk,
  input  logic       rst,
  input  logic       op_valid,
  input  logic [4:0] op_sel,
  input  logic [7:0] opa,
  input  logic [7:0] opb,
  input  logic [2:0] bit_sel,
  input  logic       irq_enter,
  input  logic       mask_load,
  input  logic [1:0] mask_wdata,
  output logic [7:0] result,
  output logic       res_we,
  output logic [7:0] ccr
);

  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_CMP = 5'd4,  OP_INC = 5'd5,  OP_DEC = 5'd6,  OP_NEG = 5'd7;
  localparam logic [4:0] OP_AND = 5'd8,  OP_OR  = 5'd9,  OP_XOR = 5'd10, OP_CPL = 5'd11;
  localparam logic [4:0] OP_LD  = 5'd12, OP_BT  = 5'd13, OP_RLC = 5'd14, OP_RRC = 5'd15;
  localparam logic [4:0] OP_SLL = 5'd16, OP_SRL = 5'd17, OP_SRA = 5'd18;
  localparam logic [4:0] OP_SCF = 5'd19, OP_RCF = 5'd20;

  logic v_q, i1_q, h_q, i0_q, n_q, z_q, c_q;
  logic [7:0] r;
  logic we, nz_upd, v_n, h_n, c_n;

  assign ccr = {v_q, 1'b0, i1_q, h_q, i0_q, n_q, z_q, c_q};

  wire       cin    = (op_sel == OP_ADC) & c_q;
  wire [8:0] add_s  = {1'b0, opa} + {1'b0, opb} + {8'd0, cin};
  wire [4:0] add_lo = {1'b0, opa[3:0]} + {1'b0, opb[3:0]} + {4'd0, cin};
  wire       add_v  = (opa[7] == opb[7]) & (add_s[7] != opa[7]);

  wire       bin    = (op_sel == OP_SBC) & c_q;
  wire [8:0] sub_d  = {1'b0, opa} - {1'b0, opb} - {8'd0, bin};
  wire       sub_v  = (opa[7] != opb[7]) & (sub_d[7] != opa[7]);

  always_comb begin
    r      = opa;
    we     = 1'b0;
    nz_upd = 1'b0;
    v_n    = v_q;
    h_n    = h_q;
    c_n    = c_q;
    case (op_sel)
      OP_ADD, OP_ADC: begin
        r = add_s[7:0]; we = 1'b1; nz_upd = 1'b1;
        v_n = add_v; h_n = add_lo[4]; c_n = add_s[8];
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        r = sub_d[7:0]; we = (op_sel != OP_CMP); nz_upd = 1'b1;
        v_n = sub_v; c_n = sub_d[8];
      end
      OP_INC: begin r = opa + 8'd1; we = 1'b1; nz_upd = 1'b1; v_n = (opa == 8'h7F); end
      OP_DEC: begin r = opa - 8'd1; we = 1'b1; nz_upd = 1'b1; v_n = (opa == 8'h80); end
      OP_NEG: begin
        r = 8'd0 - opa; we = 1'b1; nz_upd = 1'b1;
        v_n = (opa == 8'h80); c_n = (opa != 8'd0);
      end
      OP_AND: begin r = opa & opb; we = 1'b1; nz_upd = 1'b1; end
      OP_OR:  begin r = opa | opb; we = 1'b1; nz_upd = 1'b1; end
      OP_XOR: begin r = opa ^ opb; we = 1'b1; nz_upd = 1'b1; end
      OP_CPL: begin r = ~opa;      we = 1'b1; nz_upd = 1'b1; end
      OP_LD:  begin r = opb;       we = 1'b1; nz_upd = 1'b1; end
      OP_BT:  c_n = opa[bit_sel];
      OP_RLC: begin r = {opa[6:0], c_q};  we = 1'b1; nz_upd = 1'b1; c_n = opa[7]; end
      OP_RRC: begin r = {c_q, opa[7:1]};  we = 1'b1; nz_upd = 1'b1; c_n = opa[0]; end
      OP_SLL: begin r = {opa[6:0], 1'b0}; we = 1'b1; nz_upd = 1'b1; c_n = opa[7]; end
      OP_SRL: begin r = {1'b0, opa[7:1]}; we = 1'b1; nz_upd = 1'b1; c_n = opa[0]; end
      OP_SRA: begin r = {opa[7], opa[7:1]}; we = 1'b1; nz_upd = 1'b1; c_n = opa[0]; end
      OP_SCF: c_n = 1'b1;
      OP_RCF: c_n = 1'b0;
      default: ;
    endcase
  end

  assign result = r;
  assign res_we = op_valid & we;

  always_ff @(posedge clk) begin
    if (rst) begin
      {v_q, h_q, n_q, z_q, c_q} <= '0;
      {i1_q, i0_q} <= 2'b11;
    end else begin
      if (op_valid) begin
        v_q <= v_n;
        h_q <= h_n;
        c_q <= c_n;
        if (nz_upd) begin
          n_q <= r[7];
          z_q <= (r == 8'd0);
        end
      end
      if (irq_enter)      {i1_q, i0_q} <= 2'b11;
      else if (mask_load) {i1_q, i0_q} <= mask_wdata;
    end
  end

endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
  input logic       clk,
  input logic       rst,
  input logic       op_valid,
  input logic [4:0] op_sel,
  input logic [7:0] opa,
  input logic [2:0] bit_sel,
  input logic       irq_enter,
  input logic       mask_load,
  input logic [1:0] mask_wdata,
  input logic [7:0] result,
  input logic       res_we,
  input logic [7:0] ccr
);

  wire nz_op = op_valid && (op_sel <= 5'd12 || (op_sel >= 5'd14 && op_sel <= 5'd18));
  wire hold  = !op_valid || op_sel >= 5'd21;

  // R1
  reset_val_chk: assert property (@(posedge clk) rst |=> ccr == 8'h28);

  // R6
  nz_track_chk: assert property (@(posedge clk) disable iff (rst)
    nz_op |=> (ccr[2] == $past(result[7])) && (ccr[1] == ($past(result) == 8'd0)));

  // R12
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> {ccr[7], ccr[4], ccr[2:0]} == $past({ccr[7], ccr[4], ccr[2:0]}));

  // R8
  bit_test_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 5'd13) |=>
      ccr[0] == $past(opa[bit_sel]) && {ccr[7], ccr[4], ccr[2:1]} == $past({ccr[7], ccr[4], ccr[2:1]}));

  // R9
  carry_force_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_sel == 5'd19 || op_sel == 5'd20)) |=>
      ccr[0] == $past(op_sel == 5'd19) && {ccr[7], ccr[4], ccr[2:1]} == $past({ccr[7], ccr[4], ccr[2:1]}));

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    irq_enter |=> ccr[5] && ccr[3]);

  // R11
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_load && !irq_enter) |=> {ccr[5], ccr[3]} == $past(mask_wdata));

  // R13
  no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_sel == 5'd4 || op_sel == 5'd13 || op_sel >= 5'd19) |-> !res_we);

endmodule

bind alu8_flags alu8_flags_chk i_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel), .opa(opa),
  .bit_sel(bit_sel), .irq_enter(irq_enter), .mask_load(mask_load),
  .mask_wdata(mask_wdata), .result(result), .res_we(res_we), .ccr(ccr)
);

// File: tb/test_alu8_flags.sv
`timescale 1ns/1ps
module test_alu8_flags;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [4:0] op_sel = '0;
  logic [7:0] opa = '0, opb = '0;
  logic [2:0] bit_sel = '0;
  logic irq_enter = 1'b0, mask_load = 1'b0;
  logic [1:0] mask_wdata = '0;
  logic [7:0] result, ccr;
  logic res_we;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  bit [7:0] m_cc;

  always #2.5 clk = ~clk;

  alu8_flags i_alu8_flags (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel), .opa(opa), .opb(opb),
    .bit_sel(bit_sel), .irq_enter(irq_enter), .mask_load(mask_load), .mask_wdata(mask_wdata),
    .result(result), .res_we(res_we), .ccr(ccr)
  );

  function automatic string tag_of(int op);
    if (op <= 1) return "R3";
    if (op <= 4) return "R4";
    if (op <= 7) return "R5";
    if (op <= 12) return "R6";
    if (op == 13) return "R8";
    if (op <= 18) return "R7";
    if (op <= 20) return "R9";
    return "R12";
  endfunction

  function automatic int sgn(int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  task automatic model(input int op, input int a, input int b, input int bs, input bit [7:0] cc,
                       output int r, output bit we, output bit [7:0] nc);
    int c, s, sr, k;
    bit nz;
    c = cc[0]; nc = cc; r = a; we = 0; nz = 0;
    case (op)
      0, 1: begin
        k = (op == 1) ? c : 0;
        s = a + b + k; r = s % 256; we = 1; nz = 1;
        nc[0] = (s > 255);
        nc[4] = ((a % 16) + (b % 16) + k) > 15;
        sr = sgn(a) + sgn(b) + k; nc[7] = (sr > 127) || (sr < -128);
      end
      2, 3, 4: begin
        k = (op == 3) ? c : 0;
        s = a - b - k; r = (s + 512) % 256; we = (op != 4); nz = 1;
        nc[0] = (s < 0);
        sr = sgn(a) - sgn(b) - k; nc[7] = (sr > 127) || (sr < -128);
      end
      5: begin r = (a + 1) % 256; we = 1; nz = 1; nc[7] = (sgn(a) + 1 > 127); end
      6: begin r = (a + 255) % 256; we = 1; nz = 1; nc[7] = (sgn(a) - 1 < -128); end
      7: begin r = (256 - a) % 256; we = 1; nz = 1; nc[7] = (-sgn(a) > 127); nc[0] = (a != 0); end
      8:  begin r = a & b; we = 1; nz = 1; end
      9:  begin r = a | b; we = 1; nz = 1; end
      10: begin r = a ^ b; we = 1; nz = 1; end
      11: begin r = 255 - a; we = 1; nz = 1; end
      12: begin r = b; we = 1; nz = 1; end
      13: nc[0] = ((a >> bs) % 2) == 1;
      14: begin r = (a * 2) % 256 + c; we = 1; nz = 1; nc[0] = (a >= 128); end
      15: begin r = c * 128 + a / 2; we = 1; nz = 1; nc[0] = (a % 2) == 1; end
      16: begin r = (a * 2) % 256; we = 1; nz = 1; nc[0] = (a >= 128); end
      17: begin r = a / 2; we = 1; nz = 1; nc[0] = (a % 2) == 1; end
      18: begin r = a / 2 + ((a >= 128) ? 128 : 0); we = 1; nz = 1; nc[0] = (a % 2) == 1; end
      19: nc[0] = 1;
      20: nc[0] = 0;
      default: ;
    endcase
    if (nz) begin nc[2] = (r >= 128); nc[1] = (r == 0); end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int op, input int a, input int b, input int bs, input bit v,
                      input bit irq, input bit ml, input int mw);
    int r;
    bit we;
    bit [7:0] nc;
    op_sel = op[4:0]; opa = a[7:0]; opb = b[7:0]; bit_sel = bs[2:0];
    op_valid = v; irq_enter = irq; mask_load = ml; mask_wdata = mw[1:0];
    model(op, a, b, bs, m_cc, r, we, nc);
    #1;
    // R13
    check(res_we == (v && we), "R13", res_we, v && we);
    if (v && we) check(result == r[7:0], tag_of(op), result, r);
    @(posedge clk);
    if (v) begin
      m_cc[7] = nc[7]; m_cc[4] = nc[4]; m_cc[2:0] = nc[2:0];
    end
    if (irq) begin m_cc[5] = 1; m_cc[3] = 1; end
    else if (ml) begin m_cc[5] = mw[1]; m_cc[3] = mw[0]; end
    @(negedge clk);
    check({ccr[7], ccr[4], ccr[2:0]} == {m_cc[7], m_cc[4], m_cc[2:0]},
          v ? tag_of(op) : "R12", ccr, m_cc);
    check({ccr[5], ccr[3]} == {m_cc[5], m_cc[3]}, irq ? "R10" : "R11", ccr, m_cc);
    // R2
    check(ccr[6] == 1'b0, "R2", ccr, m_cc);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_cc = 8'h28;
    // R1
    check(ccr == 8'h28, "R1", ccr, 8'h28);

    // R11 / R10 mask handling
    step(31, 0, 0, 0, 0, 0, 1, 2);
    step(31, 0, 0, 0, 0, 0, 1, 1);
    step(31, 0, 0, 0, 0, 0, 0, 0);
    step(31, 0, 0, 0, 0, 1, 1, 0);
    step(31, 0, 0, 0, 0, 0, 1, 0);
    // R3 boundaries
    step(0, 8'h7F, 8'h01, 0, 1, 0, 0, 0);
    step(0, 8'hFF, 8'h01, 0, 1, 0, 0, 0);
    step(1, 8'h0F, 8'h00, 0, 1, 0, 0, 0);
    step(0, 8'h80, 8'h80, 0, 1, 0, 0, 0);
    // R4
    step(2, 8'h00, 8'h01, 0, 1, 0, 0, 0);
    step(3, 8'h80, 8'h00, 0, 1, 0, 0, 0);
    step(4, 8'h05, 8'h05, 0, 1, 0, 0, 0);
    step(2, 8'h80, 8'h01, 0, 1, 0, 0, 0);
    // R5
    step(5, 8'h7F, 0, 0, 1, 0, 0, 0);
    step(6, 8'h80, 0, 0, 1, 0, 0, 0);
    step(7, 8'h80, 0, 0, 1, 0, 0, 0);
    step(7, 8'h00, 0, 0, 1, 0, 0, 0);
    // R9 then R7 link
    step(19, 0, 0, 0, 1, 0, 0, 0);
    step(14, 8'h80, 0, 0, 1, 0, 0, 0);
    step(15, 8'h01, 0, 0, 1, 0, 0, 0);
    step(20, 0, 0, 0, 1, 0, 0, 0);
    step(18, 8'h81, 0, 0, 1, 0, 0, 0);
    step(16, 8'h80, 0, 0, 1, 0, 0, 0);
    step(17, 8'h01, 0, 0, 1, 0, 0, 0);
    // R8
    step(13, 8'h10, 0, 4, 1, 0, 0, 0);
    step(13, 8'h10, 0, 3, 1, 0, 0, 0);
    // R6
    step(8, 8'hF0, 8'h0F, 0, 1, 0, 0, 0);
    step(11, 8'h00, 0, 0, 1, 0, 0, 0);
    step(12, 0, 8'h80, 0, 1, 0, 0, 0);
    // R12
    step(0, 8'hFF, 8'hFF, 0, 0, 0, 0, 0);
    step(25, 8'h00, 8'h00, 0, 1, 0, 0, 0);

    for (int i = 0; i < 2000; i++) begin
      step($urandom_range(0, 31), $urandom_range(0, 255), $urandom_range(0, 255),
           $urandom_range(0, 7), ($urandom_range(0, 7) != 0),
           ($urandom_range(0, 15) == 0), ($urandom_range(0, 7) == 0), $urandom_range(0, 3));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule